// File: doc/BRIEF.md
# Battery State-of-Health Regression Datapath

This block turns five battery measurements into a state-of-health figure with a fixed linear regression. The charge drawn is formed as run time times discharge rate. That product and three ageing slopes are then scaled by constant coefficients and added to a constant bias. The three slopes are the time slopes of electrolyte specific gravity, open-circuit voltage and internal resistance. The internal-resistance term is subtracted. All values use signed Q32.32 fixed point in 64-bit words.

The datapath has three pipeline stages: capture, products and summation. It advances only on rising clock edges where the enable input is high, and it accepts one sample per enabled cycle. A sample whose run time and discharge rate are both zero counts as idle. An idle sample passes through without touching the output, so the last figure stays on the output while the battery rests. A strobe marks each edge at which a new figure is loaded.

Top module: `soh_regress_top`

## Requirements
- R1: After a synchronous active-low reset, `health` is zero and `health_valid` is low.
- R2: For a non-idle sample, `health` = KB + round(KA·AH) + round(KS·sg) + round(KV·ocv) − round(KR·ir), where AH = sat(round(run_time·dis_rate)). The raw Q32.32 coefficients are KB = 4313435655 (1.0043), KA = 37795712 (0.0088), KS = 16718160200 (3.8925), KV = 1049690007 (0.2444) and KR = 370655678 (0.0863).
- R3: Each product of two Q32.32 values is rounded to nearest, with ties going toward positive infinity: (p + 2^31) >>> 32. AH is clamped to the signed 64-bit range before it is scaled.
- R4: A sample captured at one enabled rising edge appears on `health`, with `health_valid` high, right after the second enabled edge that follows it. Back-to-back samples give back-to-back results.
- R5: At an edge where `en` is low, every stage keeps its contents. After such an edge `health_valid` is low and `health` is unchanged.
- R6: A sample with `run_time` = 0 and `dis_rate` = 0 is idle. It never raises `health_valid` and never changes `health`, whatever its slope inputs are.
- R7: The final sum saturates to 0x7FFF_FFFF_FFFF_FFFF or 0x8000_0000_0000_0000 instead of wrapping.
- R8: A sample where only one of `run_time` and `dis_rate` is zero is not idle. It produces a result whose charge term is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advances the pipeline when high |
| run_time | input | 64 | Battery run time, Q32.32 |
| dis_rate | input | 64 | Discharge rate, Q32.32 |
| slope_sg | input | 64 | Specific-gravity slope, Q32.32 |
| slope_ocv | input | 64 | Open-circuit-voltage slope, Q32.32 |
| slope_ir | input | 64 | Internal-resistance slope, Q32.32 |
| health | output | 64 | State-of-health figure, Q32.32, held between updates |
| health_valid | output | 1 | High for one cycle after each load of `health` |

## Verification
The hardest case to reach from the ports is a rounding tie. A tie only shows when a product lands exactly half an LSB above a grid point. With the other terms present, that half-LSB is buried. The stimulus isolates the open-circuit-voltage term by setting the other slopes to zero and making run time non-zero with a zero rate, so the charge term vanishes without the sample counting as idle. It then drives that slope to ±0.5, which hits a tie with the odd coefficient KV. The bench also drops enable while samples are still in flight, so that latency is counted in enabled edges rather than clock cycles.

// File: rtl/soh_regress_pkg.sv
// Package: shared widths, coefficient defaults and slope-lane indices for the
// state-of-health regression datapath. Assumes signed Q(DATA_W-FRAC_W).FRAC_W.
package soh_regress_pkg;

    localparam int DATA_W = 64;
    localparam int FRAC_W = 32;

    // Raw Q32.32 encodings of the regression constants.
    localparam logic signed [DATA_W-1:0] COEF_BIAS = 64'sd4313435655;   // 1.0043
    localparam logic signed [DATA_W-1:0] COEF_AH   = 64'sd37795712;     // 0.0088
    localparam logic signed [DATA_W-1:0] COEF_SG   = 64'sd16718160200;  // 3.8925
    localparam logic signed [DATA_W-1:0] COEF_OCV  = 64'sd1049690007;   // 0.2444
    localparam logic signed [DATA_W-1:0] COEF_IR   = 64'sd370655678;    // 0.0863

    localparam int N_SLOPE = 3;

    typedef enum int {
        LANE_SG  = 0,
        LANE_OCV = 1,
        LANE_IR  = 2
    } slope_lane_e;

endpackage

// File: rtl/soh_rmul.sv
// Module: signed fixed-point multiply with round-to-nearest (ties upward).
// Assumes both operands share FW fractional bits; OW must hold the shifted
// product (AW+BW-FW bits suffice). Purely combinational.
module soh_rmul #(
    parameter int AW = 64,
    parameter int BW = 64,
    parameter int FW = 32,
    parameter int OW = AW + BW - FW
) (
    input  logic signed [AW-1:0] op_a,
    input  logic signed [BW-1:0] op_b,
    output logic signed [OW-1:0] prod_rnd
);

    localparam int PW = AW + BW;
    localparam logic signed [PW-1:0] HALF_LSB = {{(PW-FW){1'b0}}, 1'b1, {(FW-1){1'b0}}};

    logic signed [PW-1:0] prod_full;
    logic signed [PW-1:0] prod_shift;

    // Full-width product, add half an output LSB, arithmetic shift down.
    always_comb begin
        prod_full  = PW'(op_a) * PW'(op_b);
        prod_shift = (prod_full + HALF_LSB) >>> FW;
        prod_rnd   = prod_shift[OW-1:0];
    end

endmodule

// File: rtl/soh_capture_stage.sv
// Module: stage 1. Registers the five measurements on enable and tags the
// sample as live unless run time and discharge rate are both zero.
// Assumes synchronous active-low reset.
module soh_capture_stage #(
    parameter int DW = 64,
    parameter int NS = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DW-1:0]        run_time,
    input  logic [DW-1:0]        dis_rate,
    input  logic [DW-1:0]        slope_in [NS],
    output logic [DW-1:0]        cap_time,
    output logic [DW-1:0]        cap_rate,
    output logic [DW-1:0]        cap_slope [NS],
    output logic                 cap_live
);

    logic sample_live;

    // Idle detection: a resting battery draws nothing for no time.
    always_comb sample_live = (|run_time) || (|dis_rate);

    // Capture register: loads only on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_time <= '0;
            cap_rate <= '0;
            cap_live <= 1'b0;
        end else if (en) begin
            cap_time <= run_time;
            cap_rate <= dis_rate;
            cap_live <= sample_live;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NS; gi++) begin : g_slope_reg
            // Per-slope capture register.
            always_ff @(posedge clk) begin
                if (!rst_n)  cap_slope[gi] <= '0;
                else if (en) cap_slope[gi] <= slope_in[gi];
            end
        end
    endgenerate

endmodule

// File: rtl/soh_product_stage.sv
// Module: stage 2. Forms the clamped charge product and the three rounded
// slope terms. Terms keep the full rounded width so no slope term clips.
// Assumes Q(DW-FW).FW operands and coefficients.
module soh_product_stage #(
    parameter int DW = 64,
    parameter int FW = 32,
    parameter int NS = 3,
    parameter logic signed [DW-1:0] K_SG  = 64'sd0,
    parameter logic signed [DW-1:0] K_OCV = 64'sd0,
    parameter logic signed [DW-1:0] K_IR  = 64'sd0,
    localparam int TW = 2*DW - FW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [DW-1:0]        cap_time,
    input  logic [DW-1:0]        cap_rate,
    input  logic [DW-1:0]        cap_slope [NS],
    input  logic                 cap_live,
    output logic signed [DW-1:0] ah_q,
    output logic signed [TW-1:0] term_q [NS],
    output logic                 prod_live
);

    localparam logic signed [TW-1:0] AH_MAX = TW'({1'b0, {(DW-1){1'b1}}});
    localparam logic signed [TW-1:0] AH_MIN = -AH_MAX - TW'(1);
    localparam logic signed [DW-1:0] K_LANE [NS] = '{K_SG, K_OCV, K_IR};

    logic signed [TW-1:0] ah_rnd;
    logic signed [DW-1:0] ah_sat;
    logic signed [TW-1:0] term_rnd [NS];

    soh_rmul #(.AW(DW), .BW(DW), .FW(FW), .OW(TW)) u_ah_mul (
        .op_a    ($signed(cap_time)),
        .op_b    ($signed(cap_rate)),
        .prod_rnd(ah_rnd)
    );

    // Clamp the charge product into the 64-bit working range.
    always_comb begin
        if (ah_rnd > AH_MAX)      ah_sat = AH_MAX[DW-1:0];
        else if (ah_rnd < AH_MIN) ah_sat = AH_MIN[DW-1:0];
        else                      ah_sat = ah_rnd[DW-1:0];
    end

    genvar gi;
    generate
        for (gi = 0; gi < NS; gi++) begin : g_lane
            soh_rmul #(.AW(DW), .BW(DW), .FW(FW), .OW(TW)) u_lane_mul (
                .op_a    (K_LANE[gi]),
                .op_b    ($signed(cap_slope[gi])),
                .prod_rnd(term_rnd[gi])
            );
            // Product register for this slope lane.
            always_ff @(posedge clk) begin
                if (!rst_n)  term_q[gi] <= '0;
                else if (en) term_q[gi] <= term_rnd[gi];
            end
        end
    endgenerate

    // Charge-term and liveness registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ah_q      <= '0;
            prod_live <= 1'b0;
        end else if (en) begin
            ah_q      <= ah_sat;
            prod_live <= cap_live;
        end
    end

endmodule

// File: rtl/soh_sum_stage.sv
// Module: stage 3. Scales the charge term, sums bias and lane terms
// (resistance lane subtracted), saturates, and loads the held result.
// Assumes lane order sg, ocv, ir.
module soh_sum_stage #(
    parameter int DW = 64,
    parameter int FW = 32,
    parameter int NS = 3,
    parameter logic signed [DW-1:0] K_BIAS = 64'sd0,
    parameter logic signed [DW-1:0] K_AH   = 64'sd0,
    localparam int TW = 2*DW - FW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] ah_q,
    input  logic signed [TW-1:0] term_q [NS],
    input  logic                 prod_live,
    output logic [DW-1:0]        health,
    output logic                 health_valid
);

    import soh_regress_pkg::*;

    localparam int SW = TW + 3;
    localparam logic signed [SW-1:0] OUT_MAX = SW'({1'b0, {(DW-1){1'b1}}});
    localparam logic signed [SW-1:0] OUT_MIN = -OUT_MAX - SW'(1);

    logic signed [TW-1:0] ah_term;
    logic signed [SW-1:0] acc;
    logic [DW-1:0]        acc_sat;

    soh_rmul #(.AW(DW), .BW(DW), .FW(FW), .OW(TW)) u_ah_scale (
        .op_a    (K_AH),
        .op_b    (ah_q),
        .prod_rnd(ah_term)
    );

    // Affine sum in widened precision; resistance term enters negatively.
    always_comb begin
        acc = SW'(K_BIAS) + SW'(ah_term)
            + SW'(term_q[LANE_SG]) + SW'(term_q[LANE_OCV])
            - SW'(term_q[LANE_IR]);
    end

    // Clip the sum into the signed output range.
    always_comb begin
        if (acc > OUT_MAX)      acc_sat = OUT_MAX[DW-1:0];
        else if (acc < OUT_MIN) acc_sat = OUT_MIN[DW-1:0];
        else                    acc_sat = acc[DW-1:0];
    end

    // Result register: loads only for live samples on enabled edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            health       <= '0;
            health_valid <= 1'b0;
        end else begin
            health_valid <= en && prod_live;
            if (en && prod_live) health <= acc_sat;
        end
    end

endmodule

// File: rtl/soh_regress_top.sv
// Module: top of the state-of-health regression datapath. Three stages
// (capture, products, sum) advance together on enable. Assumes Q32.32 I/O.
module soh_regress_top #(
    parameter int DW = soh_regress_pkg::DATA_W,
    parameter int FW = soh_regress_pkg::FRAC_W,
    parameter logic signed [DW-1:0] K_BIAS = soh_regress_pkg::COEF_BIAS,
    parameter logic signed [DW-1:0] K_AH   = soh_regress_pkg::COEF_AH,
    parameter logic signed [DW-1:0] K_SG   = soh_regress_pkg::COEF_SG,
    parameter logic signed [DW-1:0] K_OCV  = soh_regress_pkg::COEF_OCV,
    parameter logic signed [DW-1:0] K_IR   = soh_regress_pkg::COEF_IR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [DW-1:0] run_time,
    input  logic [DW-1:0] dis_rate,
    input  logic [DW-1:0] slope_sg,
    input  logic [DW-1:0] slope_ocv,
    input  logic [DW-1:0] slope_ir,
    output logic [DW-1:0] health,
    output logic          health_valid
);

    import soh_regress_pkg::*;

    localparam int NS = N_SLOPE;
    localparam int TW = 2*DW - FW;

    logic [DW-1:0]        slope_vec [NS];
    logic [DW-1:0]        cap_time;
    logic [DW-1:0]        cap_rate;
    logic [DW-1:0]        cap_slope [NS];
    logic                 cap_live;
    logic signed [DW-1:0] ah_q;
    logic signed [TW-1:0] term_q [NS];
    logic                 prod_live;

    // Gather slope inputs into lane order.
    always_comb begin
        slope_vec[LANE_SG]  = slope_sg;
        slope_vec[LANE_OCV] = slope_ocv;
        slope_vec[LANE_IR]  = slope_ir;
    end

    soh_capture_stage #(.DW(DW), .NS(NS)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .run_time (run_time),
        .dis_rate (dis_rate),
        .slope_in (slope_vec),
        .cap_time (cap_time),
        .cap_rate (cap_rate),
        .cap_slope(cap_slope),
        .cap_live (cap_live)
    );

    soh_product_stage #(.DW(DW), .FW(FW), .NS(NS),
                        .K_SG(K_SG), .K_OCV(K_OCV), .K_IR(K_IR)) u_product (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .cap_time (cap_time),
        .cap_rate (cap_rate),
        .cap_slope(cap_slope),
        .cap_live (cap_live),
        .ah_q     (ah_q),
        .term_q   (term_q),
        .prod_live(prod_live)
    );

    soh_sum_stage #(.DW(DW), .FW(FW), .NS(NS),
                    .K_BIAS(K_BIAS), .K_AH(K_AH)) u_sum (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .ah_q        (ah_q),
        .term_q      (term_q),
        .prod_live   (prod_live),
        .health      (health),
        .health_valid(health_valid)
    );

endmodule

// File: rtl/soh_regress_checker.sv
// Module: protocol checker bound to soh_regress_top. Keeps its own two-bit
// record of live captures to check latency, gating and hold at the ports.
module soh_regress_checker #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [DW-1:0] run_time,
    input logic [DW-1:0] dis_rate,
    input logic [DW-1:0] health,
    input logic          health_valid
);

    logic live_d1;
    logic live_d2;

    // Shadow record of which enabled captures were live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_d1 <= 1'b0;
            live_d2 <= 1'b0;
        end else if (en) begin
            live_d1 <= (|run_time) || (|dis_rate);
            live_d2 <= live_d1;
        end
    end

    // R1: reset clears result and strobe.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (health == '0 && !health_valid));

    // R4: a live capture surfaces two enabled edges later.
    assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && live_d2) |=> health_valid);

    // R6: no strobe unless a live sample reaches the end on an enabled edge.
    assert_idle_silent_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && live_d2) |=> !health_valid);

    // R5: a disabled edge never yields a strobe.
    assert_stall_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !health_valid);

    // R5/R6: the result only moves together with the strobe.
    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !health_valid |-> $stable(health));

endmodule

bind soh_regress_top soh_regress_checker #(.DW(DW)) u_soh_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .en          (en),
    .run_time    (run_time),
    .dis_rate    (dis_rate),
    .health      (health),
    .health_valid(health_valid)
);

// File: tb/soh_regress_top_bench.sv
module soh_regress_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [63:0] run_time = '0, dis_rate = '0, slope_sg = '0, slope_ocv = '0, slope_ir = '0;
    logic [63:0] health;
    logic        health_valid;

    int checks = 0;
    int failures = 0;
    int en_edges = 0;
    logic en_at_edge = 1'b0;
    logic [63:0] last_seen = '0;

    typedef struct {
        logic [63:0] value;
        int          edge_no;
        string       req;
    } exp_t;
    exp_t sb[$];

    // Constants as stated in the requirements (R2).
    localparam logic signed [127:0] KB = 128'sd4313435655;
    localparam logic signed [127:0] KA = 128'sd37795712;
    localparam logic signed [127:0] KS = 128'sd16718160200;
    localparam logic signed [127:0] KV = 128'sd1049690007;
    localparam logic signed [127:0] KR = 128'sd370655678;
    localparam logic signed [127:0] MX = 128'sd9223372036854775807;
    localparam logic signed [127:0] MN = -MX - 128'sd1;

    always #10 clk = ~clk;

    soh_regress_top u_soh_regress_top (
        .clk(clk), .rst_n(rst_n), .en(en),
        .run_time(run_time), .dis_rate(dis_rate),
        .slope_sg(slope_sg), .slope_ocv(slope_ocv), .slope_ir(slope_ir),
        .health(health), .health_valid(health_valid)
    );

    function automatic logic signed [127:0] rmul(input logic signed [127:0] a, input logic signed [127:0] b);
        logic signed [127:0] p;
        p = a * b;
        return (p + (128'sd1 <<< 31)) >>> 32;
    endfunction

    function automatic logic signed [127:0] sat(input logic signed [127:0] v);
        if (v > MX) return MX;
        if (v < MN) return MN;
        return v;
    endfunction

    function automatic logic [63:0] model(input logic [63:0] t, c, sg, ocv, ir);
        logic signed [127:0] ah, s;
        ah = sat(rmul(128'($signed(t)), 128'($signed(c))));
        s  = KB + rmul(KA, ah) + rmul(KS, 128'($signed(sg)))
           + rmul(KV, 128'($signed(ocv))) - rmul(KR, 128'($signed(ir)));
        return sat(s)[63:0];
    endfunction

    function automatic logic [63:0] q(input real r);
        return 64'(longint'(r * 4294967296.0));
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    // Driver: present one enabled sample and queue its expected result.
    task automatic drive(input string req, input logic [63:0] t, c, sg, ocv, ir);
        exp_t e;
        run_time = t; dis_rate = c; slope_sg = sg; slope_ocv = ocv; slope_ir = ir;
        en = 1'b1;
        if (t != 0 || c != 0) begin
            e.value = model(t, c, sg, ocv, ir);
            e.edge_no = en_edges + 3;
            e.req = req;
            sb.push_back(e);
        end
        @(negedge clk);
    endtask

    task automatic stall(input int n);
        en = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic flush();
        repeat (4) drive("flush", '0, '0, '0, '0, '0);
    endtask

    // Count enabled edges (inputs change only at falling edges).
    always @(posedge clk) begin
        en_at_edge = en && rst_n;
        if (en && rst_n) en_edges++;
    end

    // Monitor: compare each strobed result with the scoreboard head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!en_at_edge) begin
                checks++;
                if (health_valid) begin
                    failures++;
                    $display("FAIL R5 valid after disabled edge actual=1 expected=0");
                end
            end
            if (health_valid) begin
                if (sb.size() == 0) begin
                    checks++; failures++;
                    $display("FAIL R6 unexpected result actual=%h expected=none", health);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.req, health, e.value);
                    checks++;
                    if (en_edges != e.edge_no) begin
                        failures++;
                        $display("FAIL R4 latency actual=%0d expected=%0d", en_edges, e.edge_no);
                    end
                    last_seen = health;
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 health after reset", health, 64'h0);
        check("R1 valid after reset", {63'b0, health_valid}, 64'h0);
        rst_n = 1'b1;

        // R2: back-to-back typical samples, mixed signs.
        drive("R2 fresh", q(12.5), q(3.0), q(-0.02), q(0.15), q(0.4));
        drive("R2 aged", q(100.0), q(7.25), q(-0.3), q(-0.5), q(2.0));
        drive("R2 neg", q(-4.0), q(1.5), q(0.001), q(0.0), q(-1.25));
        drive("R2 small", 64'd3, 64'd5, 64'd7, 64'd11, 64'd13);
        flush();

        // R3: tie rounding on the OCV lane (KV odd, slope = +/-0.5).
        drive("R3 tie positive", q(1.0), '0, '0, 64'h0000_0000_8000_0000, '0);
        drive("R3 tie negative", q(1.0), '0, '0, 64'hFFFF_FFFF_8000_0000, '0);
        // R3: charge product clamps before scaling.
        drive("R3 ah clamp", 64'h7FFF_FFFF_FFFF_FFFF, 64'h7FFF_FFFF_FFFF_FFFF, '0, '0, '0);
        // R8: one of time/rate zero is live.
        drive("R8 rate only", '0, q(2.0), q(0.1), '0, '0);
        flush();

        // R6: idle samples with busy slopes leave result untouched.
        drive("R6 idle", '0, '0, q(5.0), q(5.0), q(5.0));
        drive("R6 idle", '0, '0, q(-9.0), '0, q(3.0));
        flush();
        check("R6 held", health, last_seen);
        check("R6 held value", health, model(q(0.0), q(2.0), q(0.1), '0, '0));

        // R5: stall with samples mid-pipeline.
        drive("R5 s0", q(20.0), q(2.0), q(0.05), q(0.02), q(0.1));
        drive("R5 s1", q(30.0), q(2.0), q(0.06), q(0.03), q(0.2));
        stall(5);
        check("R5 held in stall", health, last_seen);
        drive("R5 s2", q(40.0), q(2.0), q(0.07), q(0.04), q(0.3));
        stall(2);
        flush();

        // R7: saturation both ways.
        drive("R7 sat high", q(1.0), '0, 64'h7FFF_FFFF_FFFF_FFFF, '0, '0);
        drive("R7 sat low", q(1.0), '0, 64'h8000_0000_0000_0000, '0, '0);
        flush();
        check("R7 last is min", health, 64'h8000_0000_0000_0000);

        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R4 results missing actual=%0d expected=0", sb.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule